// File: doc/BRIEF.md
# BCD Clock Calendar with Freezable Register Copy

This block keeps time of day and calendar date in packed BCD. Its resolution is one hundredth of a second and its range runs up to a two-digit year. A single-cycle tick enable, nominally at 32,768 Hz, drives a fractional prescaler. The prescaler turns the tick stream into steps of exactly one hundredth of a second. A chain of BCD counters advances on those steps. It covers hundredths, seconds, minutes, hours in 24-hour form, weekday, day of month, month and year, and it applies month lengths and leap years.

A host never sees the running counters directly. It reads and writes a bank of user registers over a small synchronous register port. That bank is refreshed from the counters in one go, on the step that completes each second. Two control bits can hold the bank still. The read hold lets the host read a consistent snapshot while the counters keep running. The write hold lets the host compose a new time, which is pushed into the counters when the hold is released.

A stop bit in the seconds register halts counting. A test bit in the weekday register replaces bit 0 of the seconds register with a square wave derived from the tick, for measuring the oscillator. Six calibration bits in the control register are only stored.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read as follows: offset 0 hundredths 00, offset 1 seconds 00, offset 2 minutes 00, offset 3 hours 00, offset 4 weekday 01, offset 5 date 01, offset 6 month 01, offset 7 year 00, offset 8 control 00. Unused offsets read 00.
- R2: Every TICK_HZ tick pulses advance the counters by exactly STEP_HZ hundredth steps, which is exactly one second, whatever the phase of the prescaler.
- R3: Counting follows BCD rules. Seconds and minutes wrap 59 to 00 and hours wrap 23 to 00, each carrying into the next field. The weekday runs 01 to 07 and then back to 01 on each date change.
- R4: The date wraps to 01 after the last day of the month: 28 or 29 for month 02, 30 for months 04, 06, 09 and 11, and 31 for the others. A year value divisible by 4, including 00, is a leap year. Month 12 wraps to 01 and year 99 wraps to 00.
- R5: All user time registers are loaded from the counters on the same clock edge as the step that completes a second. The hundredths register therefore reads 00 after each copy, and the registers do not change between copies.
- R6: While control bit 6 (read hold) is 1, no copy takes place and the counters keep running. After it is cleared, the next copy shows the time counted through the hold.
- R7: A write that sets the read hold on the same clock edge as a copy does not block that copy. The hold takes effect from the following copy.
- R8: While control bit 7 (write hold) is 1, no copy takes place and host writes to the time registers are kept. A control write that clears bit 7 loads all time registers into the counters, and counting resumes from those values.
- R9: Bit 7 of the seconds register stops counting while it is 1 and reads back as written. Copies resume one second after it is cleared.
- R10: While bit 6 of the weekday register is 1, bit 0 of the seconds register reads a square wave that inverts every FT_HALF tick pulses, and the weekday register reads back bit 6 as written. With bit 6 at 0, the stored seconds bit 0 reads back.
- R11: Control bits 5 to 0 (calibration sign and magnitude) are stored and read back, and they have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle enable per oscillator period |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from offset |

## Verification
A register write is visible on the read port one cycle after its write edge. Read data follows the offset combinationally. A copy lands on the very edge of the tick that completes a second, so the bench samples half a cycle after it drives. The bench drives the tick input itself and counts pulses, which lets it place each second boundary exactly on a known pulse. It uses a count one short of a boundary to show that nothing changed, and the boundary pulse itself to show the update. Same-edge cases, such as setting the read hold together with the completing pulse, are driven in a single cycle on purpose.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
    logic [7:0] hund;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                           day: 8'h01, hour: 8'h00, min: 8'h00,
                                           sec: 8'h00, hund: 8'h00};

  localparam logic [3:0] OFF_HUND  = 4'd0;
  localparam logic [3:0] OFF_SEC   = 4'd1;
  localparam logic [3:0] OFF_MIN   = 4'd2;
  localparam logic [3:0] OFF_HOUR  = 4'd3;
  localparam logic [3:0] OFF_DAY   = 4'd4;
  localparam logic [3:0] OFF_DATE  = 4'd5;
  localparam logic [3:0] OFF_MONTH = 4'd6;
  localparam logic [3:0] OFF_YEAR  = 4'd7;
  localparam logic [3:0] OFF_CTRL  = 4'd8;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] month, input logic [7:0] year);
    logic [1:0] mod4;
    mod4 = year[1:0] + {year[4], 1'b0};
    case (month)
      8'h02:                      return (mod4 == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_HZ = 32768,
  parameter int STEP_HZ = 100,
  parameter int FT_HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  output logic step_o,
  output logic ft_o
);
  localparam int AW = $clog2(TICK_HZ + STEP_HZ + 1);
  localparam int FW = $clog2(FT_HALF + 1);
  localparam logic [AW-1:0] TICK_C = AW'(TICK_HZ);
  localparam logic [AW-1:0] STEP_C = AW'(STEP_HZ);
  localparam logic [FW-1:0] FT_LAST = FW'(FT_HALF - 1);

  logic [AW-1:0] acc_q, acc_d, sum;
  logic [FW-1:0] ft_cnt_q, ft_cnt_d;
  logic          ft_q, ft_d;
  logic          acc_en;

  assign acc_en = tick_i & run_i;

  always_comb begin
    sum    = acc_q + STEP_C;
    step_o = 1'b0;
    acc_d  = acc_q;
    if (acc_en) begin
      if (sum >= TICK_C) begin
        step_o = 1'b1;
        acc_d  = sum - TICK_C;
      end else begin
        acc_d  = sum;
      end
    end
  end

  always_comb begin
    ft_cnt_d = ft_cnt_q;
    ft_d     = ft_q;
    if (tick_i) begin
      if (ft_cnt_q == FT_LAST) begin
        ft_cnt_d = '0;
        ft_d     = ~ft_q;
      end else begin
        ft_cnt_d = ft_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_cnt_q <= '0;
      ft_q     <= 1'b0;
    end else if (tick_i) begin
      ft_cnt_q <= ft_cnt_d;
      ft_q     <= ft_d;
    end
  end

  assign ft_o = ft_q;

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_q < TICK_C)
    else $error("prescaler residue out of range");

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t next_o,
  output logic      roll_o
);
  rtc_time_t  time_q, time_d;
  logic [7:0] mlast;
  logic       upd;

  assign mlast = last_date(time_q.month, time_q.year);
  assign upd   = load_i | step_i;

  always_comb begin
    time_d = time_q;
    roll_o = 1'b0;
    if (load_i) begin
      time_d          = load_val_i;
      time_d.sec[7]   = 1'b0;
      time_d.day[7:3] = 5'd0;
    end else if (step_i) begin
      if (time_q.hund == 8'h99) begin
        time_d.hund = 8'h00;
        roll_o      = 1'b1;
        if (time_q.sec == 8'h59) begin
          time_d.sec = 8'h00;
          if (time_q.min == 8'h59) begin
            time_d.min = 8'h00;
            if (time_q.hour == 8'h23) begin
              time_d.hour = 8'h00;
              time_d.day  = (time_q.day == 8'h07) ? 8'h01 : bcd_inc(time_q.day);
              if (time_q.date == mlast) begin
                time_d.date = 8'h01;
                if (time_q.month == 8'h12) begin
                  time_d.month = 8'h01;
                  time_d.year  = (time_q.year == 8'h99) ? 8'h00 : bcd_inc(time_q.year);
                end else begin
                  time_d.month = bcd_inc(time_q.month);
                end
              end else begin
                time_d.date = bcd_inc(time_q.date);
              end
            end else begin
              time_d.hour = bcd_inc(time_q.hour);
            end
          end else begin
            time_d.min = bcd_inc(time_q.min);
          end
        end else begin
          time_d.sec = bcd_inc(time_q.sec);
        end
      end else begin
        time_d.hund = bcd_inc(time_q.hund);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   time_q <= RTC_RESET_TIME;
    else if (upd) time_q <= time_d;
  end

  assign next_o = time_d;

  // R3
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q.sec <= 8'h59) && (time_q.min <= 8'h59) && (time_q.hour <= 8'h23))
    else $error("time field out of range");

  // R4
  date_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q.date >= 8'h01) && (time_q.date <= 8'h31) && (time_q.month >= 8'h01) && (time_q.month <= 8'h12))
    else $error("date or month out of range");

  // R2
  hund_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && time_q.hund == 8'h99) |=> (time_q.hund == 8'h00))
    else $error("hundredths did not wrap");

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       roll_i,
  input  rtc_time_t  next_i,
  input  logic       ft_i,
  output logic [7:0] rdata_o,
  output rtc_time_t  shadow_o,
  output logic       load_o,
  output logic       run_o
);
  rtc_time_t  sh_q, sh_d;
  logic [7:0] ctrl_q, ctrl_d;
  logic       copy_en, ctrl_wr, sh_en;

  assign ctrl_wr = we_i && (addr_i == OFF_CTRL);
  assign copy_en = roll_i && !ctrl_q[6] && !ctrl_q[7];
  assign load_o  = ctrl_wr && ctrl_q[7] && !wdata_i[7];
  assign sh_en   = copy_en | we_i;
  assign ctrl_d  = ctrl_wr ? wdata_i : ctrl_q;

  always_comb begin
    sh_d = sh_q;
    if (copy_en) begin
      sh_d        = next_i;
      sh_d.sec[7] = sh_q.sec[7];
      sh_d.day[6] = sh_q.day[6];
    end
    if (we_i) begin
      case (addr_i)
        OFF_HUND:  sh_d.hund  = wdata_i;
        OFF_SEC:   sh_d.sec   = wdata_i;
        OFF_MIN:   sh_d.min   = wdata_i;
        OFF_HOUR:  sh_d.hour  = wdata_i;
        OFF_DAY:   sh_d.day   = wdata_i;
        OFF_DATE:  sh_d.date  = wdata_i;
        OFF_MONTH: sh_d.month = wdata_i;
        OFF_YEAR:  sh_d.year  = wdata_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= RTC_RESET_TIME;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 8'h00;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_comb begin
    case (addr_i)
      OFF_HUND:  rdata_o = sh_q.hund;
      OFF_SEC:   rdata_o = {sh_q.sec[7:1], sh_q.day[6] ? ft_i : sh_q.sec[0]};
      OFF_MIN:   rdata_o = sh_q.min;
      OFF_HOUR:  rdata_o = sh_q.hour;
      OFF_DAY:   rdata_o = sh_q.day;
      OFF_DATE:  rdata_o = sh_q.date;
      OFF_MONTH: rdata_o = sh_q.month;
      OFF_YEAR:  rdata_o = sh_q.year;
      OFF_CTRL:  rdata_o = ctrl_q;
      default:   rdata_o = 8'h00;
    endcase
  end

  assign shadow_o = sh_q;
  assign run_o    = ~sh_q.sec[7];

  // R6
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !we_i) |=> $stable(sh_q))
    else $error("user registers changed under read hold");

  // R5
  copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_i && !ctrl_q[6] && !ctrl_q[7] && !we_i) |=>
      (sh_q.hund == $past(next_i.hund)) && (sh_q.sec[6:0] == $past(next_i.sec[6:0])) &&
      (sh_q.min == $past(next_i.min)) && (sh_q.date == $past(next_i.date)) &&
      (sh_q.year == $past(next_i.year)))
    else $error("copy did not capture counters");

  // R9
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_q.sec[7] |-> !roll_i)
    else $error("counters rolled while stopped");

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int TICK_HZ = 32768,
  parameter int STEP_HZ = 100,
  parameter int FT_HALF = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       reg_we_i,
  input  logic [3:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       step, ft, run, load, roll;
  rtc_time_t  next_time, shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  rtc_prescaler #(.TICK_HZ(TICK_HZ), .STEP_HZ(STEP_HZ), .FT_HALF(FT_HALF)) u_presc (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick_i), .run_i(run),
    .step_o(step), .ft_o(ft)
  );

  rtc_time_core u_core (
    .clk(clk), .rst_n(rst_int_n), .step_i(step), .load_i(load),
    .load_val_i(shadow), .next_o(next_time), .roll_o(roll)
  );

  rtc_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .roll_i(roll), .next_i(next_time), .ft_i(ft),
    .rdata_o(reg_rdata_o), .shadow_o(shadow), .load_o(load), .run_o(run)
  );

endmodule

// File: tb/bcd_rtc_tb_top.sv
module bcd_rtc_tb_top;
  localparam int TK  = 300;
  localparam int FTH = 4;
  localparam logic [3:0] A_HUND = 4'd0, A_SEC = 4'd1, A_MIN = 4'd2, A_HOUR = 4'd3,
                         A_DAY = 4'd4, A_DATE = 4'd5, A_MON = 4'd6, A_YEAR = 4'd7, A_CTRL = 4'd8;

  // start year, month, date -> expected year, month, date after 23:59:59 + 1 s
  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    48'h23_02_28_23_03_01, 48'h24_02_28_24_02_29, 48'h24_02_29_24_03_01,
    48'h23_04_30_23_05_01, 48'h23_01_31_23_02_01, 48'h00_02_28_00_02_29,
    48'h99_12_31_00_01_01
  };

  logic clk = 1'b0;
  logic rst_n, tick, we;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  bcd_rtc #(.TICK_HZ(TK), .STEP_HZ(100), .FT_HALF(FTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic tick_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); tick = 1'b1; addr = a; wdata = d; we = 1'b1;
    @(negedge clk); tick = 1'b0; we = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, dw, h, mi, s);
    wr(A_CTRL, 8'h80);
    wr(A_YEAR, y); wr(A_MON, mo); wr(A_DATE, d); wr(A_DAY, dw);
    wr(A_HOUR, h); wr(A_MIN, mi); wr(A_SEC, s); wr(A_HUND, 8'h00);
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b0, v;
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    expect_reg("R1 hund", A_HUND, 8'h00);  expect_reg("R1 sec", A_SEC, 8'h00);
    expect_reg("R1 min", A_MIN, 8'h00);    expect_reg("R1 hour", A_HOUR, 8'h00);
    expect_reg("R1 day", A_DAY, 8'h01);    expect_reg("R1 date", A_DATE, 8'h01);
    expect_reg("R1 month", A_MON, 8'h01);  expect_reg("R1 year", A_YEAR, 8'h00);
    expect_reg("R1 ctrl", A_CTRL, 8'h00);  expect_reg("R1 unused", 4'd12, 8'h00);

    // R5 no change one pulse before the boundary, R2 exact second
    ticks(TK - 1);
    expect_reg("R5 sec before copy", A_SEC, 8'h00);
    ticks(1);
    expect_reg("R2 sec after one second", A_SEC, 8'h01);
    expect_reg("R5 hund after copy", A_HUND, 8'h00);

    // R7 hold written on the copy edge; R6 hold then release
    ticks(TK - 1);
    tick_wr(A_CTRL, 8'h40);
    expect_reg("R7 copy on hold edge", A_SEC, 8'h02);
    ticks(2 * TK);
    expect_reg("R6 held sec", A_SEC, 8'h02);
    expect_reg("R6 ctrl readback", A_CTRL, 8'h40);
    wr(A_CTRL, 8'h00);
    ticks(TK);
    expect_reg("R6 counters ran", A_SEC, 8'h05);

    // R11 calibration bits
    wr(A_CTRL, 8'h2A);
    expect_reg("R11 ctrl readback", A_CTRL, 8'h2A);
    ticks(TK);
    expect_reg("R11 counting unaffected", A_SEC, 8'h06);
    wr(A_CTRL, 8'h00);

    // R3 BCD carry into hours tens
    set_time(8'h24, 8'h05, 8'h15, 8'h03, 8'h09, 8'h59, 8'h59);
    ticks(TK);
    expect_reg("R3 hour carry", A_HOUR, 8'h10);
    expect_reg("R3 min wrap", A_MIN, 8'h00);
    expect_reg("R3 sec wrap", A_SEC, 8'h00);
    expect_reg("R3 day kept", A_DAY, 8'h03);

    // R4/R8 month ends, leap years, weekday wrap
    for (int i = 0; i < NV; i++) begin
      set_time(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], 8'h07, 8'h23, 8'h59, 8'h59);
      ticks(TK);
      expect_reg("R4 year", A_YEAR, VEC[i][23:16]);
      expect_reg("R4 month", A_MON, VEC[i][15:8]);
      expect_reg("R4 date", A_DATE, VEC[i][7:0]);
      expect_reg("R3 weekday wrap", A_DAY, 8'h01);
      expect_reg("R8 hour after load", A_HOUR, 8'h00);
    end

    // R8 write hold keeps host data, release loads counters
    wr(A_CTRL, 8'h80);
    wr(A_MIN, 8'h30);
    ticks(TK);
    expect_reg("R8 held write", A_MIN, 8'h30);
    expect_reg("R8 ctrl readback", A_CTRL, 8'h80);
    wr(A_CTRL, 8'h00);
    ticks(TK);
    expect_reg("R8 loaded min", A_MIN, 8'h30);
    expect_reg("R8 loaded sec", A_SEC, 8'h01);

    // R9 oscillator stop
    wr(A_SEC, 8'h80);
    ticks(2 * TK);
    expect_reg("R9 stopped", A_SEC, 8'h80);
    wr(A_SEC, 8'h00);
    ticks(TK);
    expect_reg("R9 resumed", A_SEC, 8'h02);
    expect_reg("R9 min", A_MIN, 8'h30);

    // R10 frequency test output
    wr(A_DAY, 8'h41);
    expect_reg("R10 day readback", A_DAY, 8'h41);
    rd(A_SEC, b0);
    ticks(FTH);
    rd(A_SEC, v);
    check("R10 wave toggled", {7'd0, v[0]}, {7'd0, ~b0[0]});
    ticks(FTH);
    rd(A_SEC, v);
    check("R10 wave back", {7'd0, v[0]}, {7'd0, b0[0]});
    wr(A_DAY, 8'h01);
    expect_reg("R10 stored bit", A_SEC, 8'h02);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule